// File: doc/BRIEF.md
# Serial Register Access Slave

This block is the slave end of a four-wire serial configuration link. It holds a bank of byte-wide configuration registers and lets an external master write or read them one at a time. The master frames each access with an active-low select. It clocks command bits in on the falling edge of the serial clock and takes read data on the rising edge.

A frame opens with a start bit of 1. An operation bit follows, with 1 meaning read and 0 meaning write. The register address comes next, most significant bit first. A write frame then carries one data byte, MSB first. On a read, the slave answers on the rising edges after the address: first a 0 marker, then the register byte MSB first. The line keeps repeating the final data bit for as long as the master keeps clocking. All three link inputs pass through synchronizers, so the whole block runs from one fast system clock. The serial clock must stay slow compared with that clock.

Top module: `sra_slave`

## Requirements
- R1: A frame of start bit 1, operation bit 0, 8 address bits and 8 data bits (all MSB first, sampled on serial-clock falling edges) stores the data byte in the addressed register.
- R2: A frame of start bit 1, operation bit 1 and 8 address bits makes the data output show a 0 marker on the next serial-clock rising edge. The addressed byte follows, MSB first, one bit per rising edge.
- R3: Rising edges after the data LSB of a read keep the data output at that LSB.
- R4: In a write frame, bits after the 8th data bit are ignored. No other register changes, and the addressed register keeps the first data byte.
- R5: A frame whose start bit is 0 is ignored until select falls again, even if a well-formed write follows it within the same select window.
- R6: Raising select in the middle of a frame abandons that frame without a write. The next select falling edge starts a fresh frame.
- R7: After reset every register reads as 0x00.
- R8: The data output is low while select is high and during the command part of a read frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data into the slave |
| sdo | output | 1 | Serial data out of the slave |

## Verification
The table walk writes eight address/data pairs and reads them back. The pairs include the lowest and highest addresses and the all-ones, all-zeros and single-bit data bytes. These catch bit-order and address-decode faults and show whether the marker precedes the data. An overlong write is paired with a read of the address that its extra bits would form, which tells a truncated frame from a double commit. A frame led by a 0 start bit and followed by a valid write separates "ignore until select falls" from "wait for the next 1". An aborted partial write followed by a full one checks that the bit counter restarts.

// File: rtl/sra_pkg.sv
package sra_pkg;
   typedef enum logic [2:0] {
      FS_START = 3'd0,
      FS_OP    = 3'd1,
      FS_ADDR  = 3'd2,
      FS_WDATA = 3'd3,
      FS_READ  = 3'd4,
      FS_DONE  = 3'd5
   } frame_state_t;

   localparam logic OP_READ = 1'b1;
endpackage

// File: rtl/sra_sync.sv
module sra_sync #(
   parameter int            WIDTH   = 1,
   parameter int            STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sra_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= RST_VAL;
            else        chain_q[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= RST_VAL;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/sra_regbank.sv
module sra_regbank #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   if (ADDR_W > 10) begin : g_bad_depth
      $error("sra_regbank: ADDR_W too large for a flop bank");
   end

   logic [DATA_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else if (we) begin
         mem_q[waddr] <= wdata;
      end
   end

   assign rdata = mem_q[raddr];

   assert_write_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> mem_q[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/sra_frame.sv
module sra_frame
   import sra_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_act,
   input  logic              sclk_fall,
   input  logic              sclk_rise,
   input  logic              din,
   input  logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] addr,
   output logic              wr_en,
   output logic [DATA_W-1:0] wr_data,
   output logic              dout
);
   localparam int MAXF  = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
   localparam int CNT_W = $clog2(MAXF) + 1;

   if (ADDR_W < 2 || DATA_W < 2) begin : g_bad_width
      $error("sra_frame: ADDR_W and DATA_W must be at least 2");
   end

   frame_state_t      state_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              op_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic              wr_q, load_q, armed_q, active_q, wr_seen_q;
   logic [DATA_W:0]   shreg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= FS_START;
         cnt_q    <= '0;
         op_q     <= 1'b0;
         addr_q   <= '0;
         data_q   <= '0;
         wr_q     <= 1'b0;
         load_q   <= 1'b0;
         armed_q  <= 1'b0;
         active_q <= 1'b0;
         shreg_q  <= '0;
      end else if (!cs_act) begin
         state_q  <= FS_START;
         cnt_q    <= '0;
         wr_q     <= 1'b0;
         load_q   <= 1'b0;
         armed_q  <= 1'b0;
         active_q <= 1'b0;
      end else begin
         wr_q   <= 1'b0;
         load_q <= 1'b0;
         if (sclk_fall) begin
            unique case (state_q)
               FS_START: state_q <= din ? FS_OP : FS_DONE;
               FS_OP: begin
                  op_q    <= din;
                  cnt_q   <= '0;
                  state_q <= FS_ADDR;
               end
               FS_ADDR: begin
                  addr_q <= {addr_q[ADDR_W-2:0], din};
                  if (cnt_q == CNT_W'(ADDR_W-1)) begin
                     cnt_q <= '0;
                     if (op_q == OP_READ) begin
                        state_q <= FS_READ;
                        load_q  <= 1'b1;
                     end else begin
                        state_q <= FS_WDATA;
                     end
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               FS_WDATA: begin
                  data_q <= {data_q[DATA_W-2:0], din};
                  if (cnt_q == CNT_W'(DATA_W-1)) begin
                     wr_q    <= 1'b1;
                     state_q <= FS_DONE;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               default: state_q <= state_q;
            endcase
         end
         if (load_q) begin
            shreg_q <= {1'b0, rd_data};
            armed_q <= 1'b1;
         end else if (sclk_rise && armed_q) begin
            if (!active_q) active_q <= 1'b1;
            else           shreg_q  <= {shreg_q[DATA_W-1:0], shreg_q[0]};
         end
      end
   end

   assign addr    = addr_q;
   assign wr_en   = wr_q;
   assign wr_data = data_q;
   assign dout    = active_q & shreg_q[DATA_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       wr_seen_q <= 1'b0;
      else if (!cs_act) wr_seen_q <= 1'b0;
      else if (wr_q)    wr_seen_q <= 1'b1;
   end

   assert_one_write_per_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_q |-> !wr_seen_q);
   assert_write_ends_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_q |-> state_q == FS_DONE);
   assert_shift_only_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_act && !sclk_rise && !load_q) |=> $stable(shreg_q));
   assert_no_drive_before_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != FS_READ) |-> !dout);
endmodule

// File: rtl/sra_slave.sv
module sra_slave #(
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sel_n,
   input  logic sclk,
   input  logic sdi,
   output logic sdo
);
   logic [2:0]        pins_s;
   logic              sel_n_s, sclk_s, sdi_s, sclk_d;
   logic              cs_act, sclk_fall, sclk_rise;
   logic [ADDR_W-1:0] addr;
   logic              wr_en;
   logic [DATA_W-1:0] wr_data, rd_data;

   sra_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({sel_n, sclk, sdi}), .q(pins_s));

   assign {sel_n_s, sclk_s, sdi_s} = pins_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_d <= 1'b0;
      else        sclk_d <= sclk_s;
   end

   assign cs_act    = ~sel_n_s;
   assign sclk_fall = sclk_d & ~sclk_s;
   assign sclk_rise = ~sclk_d & sclk_s;

   sra_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
      .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sclk_fall(sclk_fall),
      .sclk_rise(sclk_rise), .din(sdi_s), .rd_data(rd_data), .addr(addr),
      .wr_en(wr_en), .wr_data(wr_data), .dout(sdo));

   sra_regbank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .we(wr_en), .waddr(addr), .wdata(wr_data),
      .raddr(addr), .rdata(rd_data));

   assert_quiet_when_deselected_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |=> !sdo);
   assert_no_write_when_deselected_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |=> !wr_en);
endmodule

// File: tb/sra_slave_bench.sv
module sra_slave_bench;
   localparam int HALF = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sel_n = 1'b1;
   logic sclk = 1'b0;
   logic sdi = 1'b0;
   logic sdo;
   int   total = 0;
   int   bad = 0;
   bit   finished = 1'b0;

   always #2 clk = ~clk;

   sra_slave u_sra_slave (.clk(clk), .rst_n(rst_n), .sel_n(sel_n),
                          .sclk(sclk), .sdi(sdi), .sdo(sdo));

   // each entry: {address, data}
   localparam logic [15:0] VEC [8] = '{
      16'h00A5, 16'hFF5A, 16'h80FF, 16'h0100,
      16'h4281, 16'h7F7E, 16'hC301, 16'h5580 };

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic bit_cycle(input logic b, output logic so);
      sclk = 1'b1;
      sdi  = b;
      wait_clk(HALF);
      so   = sdo;
      sclk = 1'b0;
      wait_clk(HALF);
   endtask

   task automatic send_bits(input logic [31:0] v, input int n);
      logic so;
      for (int i = n - 1; i >= 0; i--) bit_cycle(v[i], so);
   endtask

   task automatic sel_low;
      sel_n = 1'b0;
      wait_clk(HALF);
   endtask

   task automatic sel_high;
      sel_n = 1'b1;
      wait_clk(HALF);
   endtask

   task automatic write_reg(input logic [7:0] a, input logic [7:0] d);
      sel_low();
      send_bits({14'd0, 2'b10, a, d}, 18);
      sel_high();
   endtask

   task automatic read_reg(input logic [7:0] a, input int extra, output logic [7:0] d,
                           output logic marker, output int cmd_hi, output int tail_bad);
      logic so;
      cmd_hi = 0;
      tail_bad = 0;
      sel_low();
      for (int i = 9; i >= 0; i--) begin
         bit_cycle(i == 9 ? 1'b1 : (i == 8 ? 1'b1 : a[i]), so);
         if (so) cmd_hi++;
      end
      bit_cycle(1'b0, marker);
      for (int i = 7; i >= 0; i--) begin
         bit_cycle(1'b0, so);
         d[i] = so;
      end
      for (int i = 0; i < extra; i++) begin
         bit_cycle(1'b0, so);
         if (so !== d[0]) tail_bad++;
      end
      sel_high();
   endtask

   initial begin
      logic [7:0] d;
      logic       mk, so;
      int         hi, tb;
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(5);

      // R7: reset contents
      read_reg(8'h00, 0, d, mk, hi, tb);
      check(d == 8'h00, "R7", d, 8'h00);
      read_reg(8'hFF, 0, d, mk, hi, tb);
      check(d == 8'h00, "R7", d, 8'h00);
      // R8: low while deselected
      check(sdo == 1'b0, "R8 deselected", sdo, 0);

      // R1/R2: vector table
      foreach (VEC[i]) write_reg(VEC[i][15:8], VEC[i][7:0]);
      foreach (VEC[i]) begin
         read_reg(VEC[i][15:8], 0, d, mk, hi, tb);
         check(d == VEC[i][7:0], "R1 R2 data", d, VEC[i][7:0]);
         check(mk == 1'b0, "R2 marker", mk, 0);
         check(hi == 0, "R8 command phase", hi, 0);
      end

      // R3: repeated LSB on extra clocks (0x01 and 0x80 bytes)
      read_reg(8'hC3, 6, d, mk, hi, tb);
      check(tb == 0 && d == 8'h01, "R3 lsb=1", {d, 8'(tb)}, 16'h0100);
      read_reg(8'h55, 6, d, mk, hi, tb);
      check(tb == 0 && d == 8'h80, "R3 lsb=0", {d, 8'(tb)}, 16'h8000);

      // R4: overlong write
      sel_low();
      send_bits({6'd0, 2'b10, 8'h10, 8'h3C, 8'h99}, 26);
      send_bits(32'h0000_00E7, 8);
      sel_high();
      read_reg(8'h10, 0, d, mk, hi, tb);
      check(d == 8'h3C, "R4 first byte kept", d, 8'h3C);
      read_reg(8'h3C, 0, d, mk, hi, tb);
      check(d == 8'h00, "R4 no second write", d, 8'h00);
      read_reg(8'h99, 0, d, mk, hi, tb);
      check(d == 8'h00, "R4 no second write", d, 8'h00);

      // R5: leading zero start bit, then a well-formed write
      sel_low();
      send_bits({13'd0, 3'b010, 8'h20, 8'h55}, 19);
      sel_high();
      read_reg(8'h20, 0, d, mk, hi, tb);
      check(d == 8'h00, "R5 bad start ignored", d, 8'h00);

      // R6: abort mid frame, then a fresh frame
      sel_low();
      send_bits({18'd0, 2'b10, 8'h30, 4'hF}, 14);
      check(sdo == 1'b0, "R8 write frame", sdo, 0);
      sel_high();
      read_reg(8'h30, 0, d, mk, hi, tb);
      check(d == 8'h00, "R6 aborted frame no write", d, 8'h00);
      write_reg(8'h30, 8'hC3);
      read_reg(8'h30, 0, d, mk, hi, tb);
      check(d == 8'hC3, "R6 fresh frame", d, 8'hC3);

      // R6: select raised in the middle of a read data phase
      sel_low();
      send_bits({22'd0, 2'b11, 8'h30}, 10);
      bit_cycle(1'b0, so);
      bit_cycle(1'b0, so);
      check(so == 1'b1, "R2 first data bit", so, 1);
      sel_high();
      check(sdo == 1'b0, "R8 after abort", sdo, 0);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=running expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule